// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a scalar, in-order processor pipeline with five stages: fetch, decode, execute, memory and writeback. It runs a tiny instruction set of add, add-immediate, load word and store word. The program is held in an instruction array set by the `PROGRAM` parameter. The register file has eight entries and the data array is word-addressed. Both sit inside the module. Once reset is released the pipeline fetches one word per cycle and moves every instruction forward one stage per cycle. The outside world sees only the writeback port and a count of retired instructions.

Decode is the only place that produces control bits. They are split into an execute group (operand select), a memory group (read and write strobes) and a writeback group (register write and result select). Each pipeline latch carries only the groups that later stages still need. No stage stalls and no stage forwards results. Ordering between dependent instructions is the job of whoever builds the program, or of a separate hazard unit.

Instruction word layout: opcode in bits [31:25], destination register in [24:22], first source in [21:19], second source in [18:16], and a 16-bit immediate in [15:0] that is sign-extended. Opcode values: 0 = no-op, 1 = add, 2 = add-immediate, 3 = load, 4 = store. All other values are undefined.

Top module: `pipe5_core`

## Requirements
- R1: After reset is released, the instruction at program index k shows its writeback during the cycle that follows the (k+4)-th rising clock edge. Exactly one instruction enters per cycle and exactly one leaves per cycle.
- R2: Opcode 1 writes rs1+rs2 to rd. Opcode 2 writes rs1 plus the sign-extended immediate to rd. Arithmetic wraps modulo 2^XLEN.
- R3: Opcode 3 loads rd from data word (rs1+imm) mod DMEM_DEPTH. Opcode 4 stores rs2 to that same word and writes no register.
- R4: Register 0 always reads as zero. An instruction that targets register 0 changes no state and leaves wb_valid low.
- R5: Opcode 0 and every undefined opcode (for example 127) write nothing and leave wb_valid low, but they still retire.
- R6: A register read in decode returns the value being written back in that same cycle. A consumer placed three instructions after its producer therefore sees the new value.
- R7: Reset sets the PC to 0, empties every latch, and clears the registers and data memory. During reset and for the first four cycles afterwards, wb_valid is low.
- R8: The retire counter starts at 0 and rises by one for each instruction that leaves writeback. The first increment happens at the fifth edge after reset.
- R9: The PC wraps from IMEM_DEPTH-1 back to 0, and the program keeps running from the register and memory state it has built up.
- R10: A load placed directly after a store to the same word returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wb_valid | output | 1 | A register write is happening this cycle |
| wb_dst | output | 3 | Destination register of the instruction in writeback |
| wb_data | output | XLEN | Value being written back |
| retired | output | RET_W | Number of instructions that have left writeback |

## Verification
The assertions assume the clock runs without gaps and that reset lasts at least one edge. They also assume the program contains no read-after-write pair closer than three instructions apart, because without stalls or forwarding such a pair is allowed to read a stale value. The test program honours this spacing and keeps it across the wrap from the last index back to the first. The same program exercises the immediate at its most negative value, a negative address that wraps, the highest data address, an undefined opcode and a load placed right after a store.

// File: rtl/pipe5_core.sv
module pipe5_core #(
  parameter int XLEN = 32,
  parameter int IMEM_DEPTH = 32,
  parameter int DMEM_DEPTH = 16,
  parameter int RET_W = 32,
  parameter logic [32*IMEM_DEPTH-1:0] PROGRAM = '0
) (
  input  logic             clk,
  input  logic             rst,
  output logic             wb_valid,
  output logic [2:0]       wb_dst,
  output logic [XLEN-1:0]  wb_data,
  output logic [RET_W-1:0] retired
);
  localparam int PCW  = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1;
  localparam int DAW  = (DMEM_DEPTH > 1) ? $clog2(DMEM_DEPTH) : 1;
  localparam int NREG = 8;
  localparam logic [6:0] OP_ADD  = 7'd1;
  localparam logic [6:0] OP_ADDI = 7'd2;
  localparam logic [6:0] OP_LW   = 7'd3;
  localparam logic [6:0] OP_SW   = 7'd4;

  // fetch
  logic [PCW-1:0] pc;
  logic [31:0]    f_ir;
  logic           fd_valid;
  logic [PCW-1:0] fd_pc;
  logic [31:0]    fd_ir;

  assign f_ir = PROGRAM[32*pc +: 32];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      fd_valid <= 1'b0;
      fd_pc    <= '0;
      fd_ir    <= '0;
    end else begin
      pc       <= pc + 1'b1;
      fd_valid <= 1'b1;
      fd_pc    <= pc;
      fd_ir    <= f_ir;
    end
  end

  // decode
  logic [6:0]      d_op;
  logic [2:0]      d_rd, d_rs1, d_rs2;
  logic [XLEN-1:0] d_imm, d_a, d_b;
  logic            d_use_imm, d_mrd, d_mwr, d_rwr, d_sel_mem;
  logic [XLEN-1:0] rf [NREG];
  logic            wb_we;

  assign d_op  = fd_ir[31:25];
  assign d_rd  = fd_ir[24:22];
  assign d_rs1 = fd_ir[21:19];
  assign d_rs2 = fd_ir[18:16];
  assign d_imm = {{(XLEN-16){fd_ir[15]}}, fd_ir[15:0]};

  assign d_use_imm = (d_op == OP_ADDI) || (d_op == OP_LW) || (d_op == OP_SW);
  assign d_mrd     = (d_op == OP_LW);
  assign d_mwr     = (d_op == OP_SW);
  assign d_rwr     = (d_op == OP_ADD) || (d_op == OP_ADDI) || (d_op == OP_LW);
  assign d_sel_mem = (d_op == OP_LW);

  always_comb begin
    if (d_rs1 == 3'd0)                  d_a = '0;
    else if (wb_we && wb_dst == d_rs1)  d_a = wb_data;
    else                                d_a = rf[d_rs1];
    if (d_rs2 == 3'd0)                  d_b = '0;
    else if (wb_we && wb_dst == d_rs2)  d_b = wb_data;
    else                                d_b = rf[d_rs2];
  end

  logic            dx_valid;
  logic [PCW-1:0]  dx_pc;
  logic [XLEN-1:0] dx_a, dx_b, dx_imm;
  logic [2:0]      dx_rd;
  logic            dx_use_imm, dx_mrd, dx_mwr, dx_rwr, dx_sel_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      dx_valid   <= 1'b0;
      dx_pc      <= '0;
      dx_a       <= '0;
      dx_b       <= '0;
      dx_imm     <= '0;
      dx_rd      <= '0;
      dx_use_imm <= 1'b0;
      dx_mrd     <= 1'b0;
      dx_mwr     <= 1'b0;
      dx_rwr     <= 1'b0;
      dx_sel_mem <= 1'b0;
    end else begin
      dx_valid   <= fd_valid;
      dx_pc      <= fd_pc;
      dx_a       <= d_a;
      dx_b       <= d_b;
      dx_imm     <= d_imm;
      dx_rd      <= d_rd;
      dx_use_imm <= d_use_imm;
      dx_mrd     <= d_mrd & fd_valid;
      dx_mwr     <= d_mwr & fd_valid;
      dx_rwr     <= d_rwr & fd_valid;
      dx_sel_mem <= d_sel_mem;
    end
  end

  // execute: the execute control group and the PC stop here
  logic [XLEN-1:0] x_o;
  assign x_o = dx_a + (dx_use_imm ? dx_imm : dx_b);

  logic            xm_valid;
  logic [XLEN-1:0] xm_o, xm_b;
  logic [2:0]      xm_rd;
  logic            xm_mrd, xm_mwr, xm_rwr, xm_sel_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      xm_valid   <= 1'b0;
      xm_o       <= '0;
      xm_b       <= '0;
      xm_rd      <= '0;
      xm_mrd     <= 1'b0;
      xm_mwr     <= 1'b0;
      xm_rwr     <= 1'b0;
      xm_sel_mem <= 1'b0;
    end else begin
      xm_valid   <= dx_valid;
      xm_o       <= x_o;
      xm_b       <= dx_b;
      xm_rd      <= dx_rd;
      xm_mrd     <= dx_mrd;
      xm_mwr     <= dx_mwr;
      xm_rwr     <= dx_rwr;
      xm_sel_mem <= dx_sel_mem;
    end
  end

  // memory: the memory control group stops here
  logic [XLEN-1:0] dmem [DMEM_DEPTH];
  logic [DAW-1:0]  m_addr;
  logic [XLEN-1:0] m_d;

  assign m_addr = xm_o[DAW-1:0];
  assign m_d    = xm_mrd ? dmem[m_addr] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_DEPTH; i++) dmem[i] <= '0;
    end else if (xm_mwr) begin
      dmem[m_addr] <= xm_b;
    end
  end

  logic            mw_valid;
  logic [XLEN-1:0] mw_o, mw_d;
  logic [2:0]      mw_rd;
  logic            mw_rwr, mw_sel_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mw_valid   <= 1'b0;
      mw_o       <= '0;
      mw_d       <= '0;
      mw_rd      <= '0;
      mw_rwr     <= 1'b0;
      mw_sel_mem <= 1'b0;
    end else begin
      mw_valid   <= xm_valid;
      mw_o       <= xm_o;
      mw_d       <= m_d;
      mw_rd      <= xm_rd;
      mw_rwr     <= xm_rwr;
      mw_sel_mem <= xm_sel_mem;
    end
  end

  // writeback
  assign wb_we    = mw_valid && mw_rwr && (mw_rd != 3'd0);
  assign wb_valid = wb_we;
  assign wb_dst   = mw_rd;
  assign wb_data  = mw_sel_mem ? mw_d : mw_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      retired <= '0;
    end else begin
      if (wb_we) rf[mw_rd] <= wb_data;
      if (mw_valid) retired <= retired + 1'b1;
    end
  end

  // R1
  stage_advance_chk: assert property (@(posedge clk) disable iff (rst)
    dx_valid |=> xm_valid && xm_rd == $past(dx_rd) && xm_b == $past(dx_b));

  // R1
  pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    dx_valid |-> dx_pc == $past(fd_pc));

  // R4
  zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_dst != 3'd0);

  // R7
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fd_valid && !dx_valid && !xm_valid && !mw_valid && retired == '0);

  // R8
  retire_step_chk: assert property (@(posedge clk) disable iff (rst)
    mw_valid |=> retired == $past(retired) + 1'b1);

  // R8
  retire_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mw_valid |=> $stable(retired));

  // R3
  store_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    xm_mwr |-> xm_valid && !xm_rwr);
endmodule

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb;
  localparam int DEPTH = 32;
  localparam int DMEM  = 16;
  localparam int RUN   = 130;

  function automatic logic [31:0] enc(int op, int rd, int rs1, int rs2, int imm);
    logic [31:0] w;
    w = {op[6:0], rd[2:0], rs1[2:0], rs2[2:0], imm[15:0]};
    return w;
  endfunction

  function automatic logic [32*DEPTH-1:0] build();
    logic [32*DEPTH-1:0] p;
    p = '0;
    p[32*0  +: 32] = enc(2, 1, 0, 0, 5);        // addi r1 = 5
    p[32*1  +: 32] = enc(2, 2, 0, 0, -3);       // addi r2 = -3
    p[32*2  +: 32] = enc(2, 3, 0, 0, 100);      // addi r3 = 100
    p[32*3  +: 32] = enc(1, 4, 1, 1, 0);        // add r4 = r1+r1
    p[32*4  +: 32] = enc(2, 5, 2, 0, 7);        // addi r5 = r2+7
    p[32*5  +: 32] = enc(4, 0, 0, 3, 2);        // sw r3 -> [2]
    p[32*6  +: 32] = enc(4, 0, 1, 4, 1);        // sw r4 -> [r1+1]
    p[32*7  +: 32] = enc(3, 6, 0, 0, 2);        // lw r6 <- [2]
    p[32*8  +: 32] = enc(3, 7, 0, 0, 6);        // lw r7 <- [6]
    p[32*9  +: 32] = enc(1, 0, 1, 1, 0);        // add r0 (discarded)
    p[32*10 +: 32] = enc(2, 1, 1, 0, 1);        // addi r1 += 1
    p[32*11 +: 32] = enc(1, 2, 6, 7, 0);        // add r2 = r6+r7
    p[32*12 +: 32] = enc(4, 0, 0, 5, 15);       // sw r5 -> [15]
    p[32*13 +: 32] = enc(3, 3, 0, 0, 15);       // lw r3 <- [15] right after store
    p[32*14 +: 32] = enc(2, 4, 0, 0, -32768);   // most negative immediate
    p[32*15 +: 32] = enc(1, 5, 0, 0, 0);        // add r5 = 0
    p[32*16 +: 32] = enc(3, 6, 0, 0, -1);       // negative address wraps to 15
    p[32*17 +: 32] = enc(127, 7, 1, 1, 3);      // undefined opcode
    p[32*18 +: 32] = enc(3, 7, 0, 0, 9);        // lw never-written word
    return p;
  endfunction

  localparam logic [32*DEPTH-1:0] PROG = build();

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_valid;
  logic [2:0]  wb_dst;
  logic [31:0] wb_data;
  logic [31:0] retired;

  always #2 clk = ~clk;

  pipe5_core #(.XLEN(32), .IMEM_DEPTH(DEPTH), .DMEM_DEPTH(DMEM), .RET_W(32), .PROGRAM(PROG)) u_dut (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_dst(wb_dst),
    .wb_data(wb_data), .retired(retired)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] mreg [8];
  logic [31:0] mmem [DMEM];
  logic        e_valid;
  logic [2:0]  e_dst;
  logic [31:0] e_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input int k);
    logic [31:0] ir, a, b, imm, v;
    int op, rd, rs1, rs2, addr;
    bit w;
    ir  = PROG[32*k +: 32];
    op  = int'(ir[31:25]);
    rd  = int'(ir[24:22]);
    rs1 = int'(ir[21:19]);
    rs2 = int'(ir[18:16]);
    imm = {{16{ir[15]}}, ir[15:0]};
    a = (rs1 == 0) ? 32'd0 : mreg[rs1];
    b = (rs2 == 0) ? 32'd0 : mreg[rs2];
    addr = int'((a + imm) % DMEM);
    w = 1'b0;
    v = '0;
    case (op)
      1: begin v = a + b; w = 1'b1; end
      2: begin v = a + imm; w = 1'b1; end
      3: begin v = mmem[addr]; w = 1'b1; end
      4: mmem[addr] = b;
      default: ;
    endcase
    e_valid = w && rd != 0;
    e_dst = rd[2:0];
    e_data = v;
    if (e_valid) mreg[rd] = v;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    for (int i = 0; i < DMEM; i++) mmem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wb_valid == 1'b0, "R7 reset wb_valid", {31'd0, wb_valid}, 32'd0);
    chk(retired == 32'd0, "R7 reset retired", retired, 32'd0);
    rst = 1'b0;
    for (int cyc = 1; cyc <= RUN; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      if (cyc >= 4) model_step((cyc - 4) % DEPTH);
      else e_valid = 1'b0;
      // R1 R2 R3 R4 R5 R6 R9 R10: writeback compared every cycle against the model
      chk(wb_valid == e_valid, "R1/R5 wb_valid", {31'd0, wb_valid}, {31'd0, e_valid});
      if (e_valid) begin
        chk(wb_dst == e_dst, "R2/R4 wb_dst", {29'd0, wb_dst}, {29'd0, e_dst});
        chk(wb_data == e_data, "R2/R3/R6/R10 wb_data", wb_data, e_data);
      end
      // R8
      chk(retired == ((cyc >= 4) ? cyc - 4 : 0), "R8 retired", retired, (cyc >= 4) ? cyc - 4 : 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule